// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 39-bit virtual address into a physical address by walking a radix page table of three levels. Each table sits in memory as 512 entries of 64 bits. A request carries the virtual address, the kind of access (read, write or instruction fetch) and whether the access comes from user mode. The root table's physical page number comes in on its own input. The walker fetches one entry per level through a simple valid/ready read port and waits for the response on that port.

For each entry it reads, the walker decides whether the entry points to the next table or is a final mapping. A final mapping can appear at any level: at the lowest level it maps a 4 KiB page, at the middle level a 2 MiB page, and at the root level a 1 GiB page. The walker then checks the entry's permissions, the user bit, the accessed and dirty bits and the alignment of the page. It returns a one-cycle result that holds either a physical address with a page-size code or a page-fault cause chosen by access kind. It never writes entries back to memory.

Top module: `pt_walker`

## Requirements
- R1: The walk starts at the root table and uses VPN bits 38:30, then 29:21, then 20:12. Each entry read uses the address {table PPN, 9-bit VPN field, 3'b000}, and the address is held steady while the read port is stalled.
- R2: Entry bit fields are V=0, R=1, W=2, X=3, U=4, A=6, D=7, with the PPN in bits 53:10. An entry with V=1 and R=W=X=0 is a pointer, so the walk continues at the table it names. A final entry at level 0 gives done_size=0 and done_paddr={PPN, vaddr[11:0]}.
- R3: A final entry at level 1 gives done_size=1 and done_paddr={PPN[43:9], vaddr[20:0]}. A final entry at level 2 gives done_size=2 and done_paddr={PPN[43:18], vaddr[29:0]}.
- R4: An entry with V=0 ends the walk with a fault. done_cause is 12 for a fetch (req_kind=2), 13 for a read (req_kind=0, and also code 3) and 15 for a write (req_kind=1). On any fault, done_paddr and done_size are zero.
- R5: An entry with W=1 and R=0, or with any of bits 63:54 set, faults.
- R6: A final entry must allow the access: a read needs R=1, a write needs W=1 and a fetch needs X=1. Otherwise the access faults.
- R7: A user access (req_user=1) needs U=1 in the final entry. A supervisor access is not checked against U.
- R8: A pointer entry found at level 0 faults.
- R9: A level-1 final entry with PPN[8:0] nonzero, or a level-2 final entry with PPN[17:0] nonzero, faults.
- R10: A final entry with A=0 faults, and a write to a final entry with D=0 faults. A read or fetch with D=0 succeeds.
- R11: req_ready is high only while the walker is idle, and requests offered during a walk are ignored. Each accepted request produces exactly one done_valid pulse, one cycle long, after which req_ready returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 39 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 treated as read |
| req_user | input | 1 | 1 for a user-mode access |
| root_ppn | input | 44 | Root table page number |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 56 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Entry value |
| done_valid | output | 1 | One-cycle result strobe |
| done_fault | output | 1 | Walk ended in a page fault |
| done_cause | output | 4 | Fault cause 12, 13 or 15 |
| done_paddr | output | 56 | Translated physical address |
| done_size | output | 2 | 0 for 4 KiB, 1 for 2 MiB, 2 for 1 GiB |

## Verification
The hardest situation to reach from the ports is one where the faulting condition sits only in the last entry of a full three-level walk. The two pointer entries above it must be valid and must land on exactly the addresses the walker will compute. The bench therefore builds each walk backwards from a chosen virtual address and root. It places pointer entries at the computed slots and puts a final entry with randomly weakened fields at a random level, or puts no final entry at all. Memory stalls and response delays are randomized, and junk requests are offered during walks to show that they are ignored.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int OFF_W  = 12,
  parameter int VPN_W  = 9,
  parameter int PPN_W  = 44,
  parameter int LEVELS = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             req_valid,
  output logic                             req_ready,
  input  logic [OFF_W+LEVELS*VPN_W-1:0]    req_vaddr,
  input  logic [1:0]                       req_kind,
  input  logic                             req_user,
  input  logic [PPN_W-1:0]                 root_ppn,
  output logic                             mem_req_valid,
  input  logic                             mem_req_ready,
  output logic [PPN_W+VPN_W+2:0]           mem_req_addr,
  input  logic                             mem_rsp_valid,
  input  logic [63:0]                      mem_rsp_data,
  output logic                             done_valid,
  output logic                             done_fault,
  output logic [3:0]                       done_cause,
  output logic [PPN_W+OFF_W-1:0]           done_paddr,
  output logic [$clog2(LEVELS)-1:0]        done_size
);
  localparam int VA_W   = OFF_W + LEVELS*VPN_W;
  localparam int PA_W   = PPN_W + OFF_W;
  localparam int LV_W   = $clog2(LEVELS);
  localparam int PPN_LO = 10;
  localparam int RES_LO = PPN_LO + PPN_W;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_DONE} state_t;

  state_t            st;
  logic [VA_W-1:0]   va;
  logic [1:0]        kind;
  logic              user;
  logic [LV_W-1:0]   lvl;
  logic [PPN_W-1:0]  tbl;

  wire is_wr = (kind == 2'd1);
  wire is_ex = (kind == 2'd2);
  wire is_rd = !is_wr && !is_ex;

  wire [VPN_W-1:0] vpn_sel = VPN_W'(va >> (OFF_W + int'(lvl)*VPN_W));

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_REQ);
  assign mem_req_addr  = {tbl, vpn_sel, 3'b000};
  assign done_valid    = (st == S_DONE);

  wire p_v = mem_rsp_data[0];
  wire p_r = mem_rsp_data[1];
  wire p_w = mem_rsp_data[2];
  wire p_x = mem_rsp_data[3];
  wire p_u = mem_rsp_data[4];
  wire p_a = mem_rsp_data[6];
  wire p_d = mem_rsp_data[7];
  wire [PPN_W-1:0] p_ppn = mem_rsp_data[PPN_LO +: PPN_W];
  wire p_resv = |mem_rsp_data[63:RES_LO];
  wire unused_pte_bits = ^{mem_rsp_data[9:8], mem_rsp_data[5]};

  wire is_ptr  = p_v && !p_r && !p_w && !p_x;
  wire bad_enc = !p_v || (p_w && !p_r) || p_resv;

  wire [PPN_W-1:0] lo_mask = ~({PPN_W{1'b1}} << (int'(lvl)*VPN_W));
  wire [PPN_W-1:0] va_pn   = PPN_W'(va[VA_W-1:OFF_W]);
  wire             misal   = |(p_ppn & lo_mask);
  wire [PPN_W-1:0] out_pn  = (p_ppn & ~lo_mask) | (va_pn & lo_mask);

  wire perm_ok    = (is_rd && p_r) || (is_wr && p_w) || (is_ex && p_x);
  wire leaf_fault = !perm_ok || (user && !p_u) || !p_a || (is_wr && !p_d) || misal;
  wire ptr_end    = is_ptr && (lvl == '0);
  wire walk_fault = bad_enc || ptr_end || (!is_ptr && leaf_fault);

  wire [3:0] fault_code = is_ex ? 4'd12 : (is_wr ? 4'd15 : 4'd13);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      va         <= '0;
      kind       <= '0;
      user       <= 1'b0;
      lvl        <= '0;
      tbl        <= '0;
      done_fault <= 1'b0;
      done_cause <= '0;
      done_paddr <= '0;
      done_size  <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va   <= req_vaddr;
          kind <= req_kind;
          user <= req_user;
          lvl  <= LV_W'(LEVELS-1);
          tbl  <= root_ppn;
          st   <= S_REQ;
        end
        S_REQ: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (walk_fault) begin
            done_fault <= 1'b1;
            done_cause <= fault_code;
            done_paddr <= '0;
            done_size  <= '0;
            st         <= S_DONE;
          end else if (is_ptr) begin
            tbl <= p_ppn;
            lvl <= lvl - 1'b1;
            st  <= S_REQ;
          end else begin
            done_fault <= 1'b0;
            done_cause <= '0;
            done_paddr <= {out_pn, va[OFF_W-1:0]};
            done_size  <= lvl;
            st         <= S_DONE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_walk_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> mem_req_valid &&
      mem_req_addr[3 +: VPN_W] == $past(req_vaddr[VA_W-1 -: VPN_W]) &&
      mem_req_addr[PA_W-1 -: PPN_W] == $past(root_ppn));

  assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr));

  assert_fault_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_fault) |-> done_paddr == '0 && done_size == '0 &&
      (done_cause == 4'd12 || done_cause == 4'd13 || done_cause == 4'd15));

  assert_size_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_fault) |-> int'(done_size) < LEVELS);

  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid && req_ready);

  assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || done_valid) |-> !req_ready);
endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [38:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_user = 0;
  logic [43:0] root_ppn = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 0;
  logic [55:0] mem_req_addr;
  logic        mem_rsp_valid = 0;
  logic [63:0] mem_rsp_data = '0;
  logic        done_valid, done_fault;
  logic [3:0]  done_cause;
  logic [55:0] done_paddr;
  logic [1:0]  done_size;

  always #2 clk = ~clk;

  pt_walker dut (.*);

  int n_tests = 0, n_fail = 0;
  logic [55:0] m_addr [3];
  logic [63:0] m_data [3];
  logic [55:0] rd_addr [8];
  int          rd_n = 0;
  logic [55:0] ex_addr [3];
  int          ex_n;
  bit          mem_busy = 0;
  int          mem_cnt = 0;
  logic [55:0] mem_hold = '0;

  function automatic logic [63:0] lookup(input logic [55:0] a);
    for (int i = 0; i < 3; i++) if (m_addr[i] == a) return m_data[i];
    return 64'd0;
  endfunction

  function automatic logic [63:0] mk(input bit v, r, w, x, u, a, d, input logic [43:0] pn);
    return {10'd0, pn, 2'd0, d, a, 1'b0, u, x, w, r, v};
  endfunction

  always @(negedge clk) begin
    mem_rsp_valid <= 0;
    if (mem_busy) begin
      if (mem_cnt == 0) begin
        mem_rsp_valid <= 1;
        mem_rsp_data  <= lookup(mem_hold);
        mem_busy      <= 0;
        mem_req_ready <= 0;
      end else mem_cnt <= mem_cnt - 1;
    end else if (mem_req_valid) begin
      if ($urandom % 4 != 0) begin
        mem_req_ready <= 1;
        mem_busy      <= 1;
        mem_cnt       <= $urandom % 3;
        mem_hold      <= mem_req_addr;
        if (rd_n < 8) rd_addr[rd_n] = mem_req_addr;
        rd_n = rd_n + 1;
      end else mem_req_ready <= 0;
    end else mem_req_ready <= 0;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [38:0] va, input logic [1:0] kind, input bit user,
                       input logic [43:0] root, output bit f, output logic [3:0] c,
                       output logic [55:0] pa, output logic [1:0] sz, output string tag);
    logic [43:0] t = root;
    logic [63:0] p;
    bit wr = (kind == 1), ex = (kind == 2), rd = !wr && !ex;
    ex_n = 0; f = 1; pa = '0; sz = '0; tag = "R8";
    c = ex ? 4'd12 : (wr ? 4'd15 : 4'd13);
    for (int l = 2; l >= 0; l--) begin
      logic [55:0] a = {t, va[12+9*l +: 9], 3'b000};
      logic [43:0] pn, lm;
      ex_addr[ex_n] = a; ex_n++;
      p = lookup(a);
      pn = p[53:10];
      if (!p[0]) begin tag = "R4"; return; end
      if ((p[2] && !p[1]) || |p[63:54]) begin tag = "R5"; return; end
      if (!p[1] && !p[2] && !p[3]) begin
        if (l == 0) begin tag = "R8"; return; end
        t = pn; continue;
      end
      if (!((rd && p[1]) || (wr && p[2]) || (ex && p[3]))) begin tag = "R6"; return; end
      if (user && !p[4]) begin tag = "R7"; return; end
      if (!p[6] || (wr && !p[7])) begin tag = "R10"; return; end
      lm = (l == 0) ? 44'd0 : ((l == 1) ? 44'h1FF : 44'h3FFFF);
      if (|(pn & lm)) begin tag = "R9"; return; end
      f = 0; c = 0; sz = 2'(l);
      pa = {(pn & ~lm) | ({17'd0, va[38:12]} & lm), va[11:0]};
      tag = (l == 0) ? "R2" : "R3";
      return;
    end
  endtask

  task automatic build(input logic [38:0] va, input logic [43:0] root, input int leaf_l,
                       input logic [63:0] leaf);
    logic [43:0] t = root;
    for (int i = 0; i < 3; i++) begin m_addr[i] = '1; m_data[i] = '0; end
    for (int l = 2; l >= 0; l--) begin
      logic [43:0] nx = {$urandom, $urandom};
      m_addr[2-l] = {t, va[12+9*l +: 9], 3'b000};
      if (l == leaf_l) begin m_data[2-l] = leaf; return; end
      m_data[2-l] = mk(1, 0, 0, 0, $urandom % 2, $urandom % 2, 0, nx);
      t = nx;
    end
  endtask

  task automatic run(input logic [38:0] va, input logic [1:0] kind, input bit user,
                     input logic [43:0] root, input bit junk, input string extra);
    bit f; logic [3:0] c; logic [55:0] pa; logic [1:0] sz; string tag;
    int wait_c = 0;
    model(va, kind, user, root, f, c, pa, sz, tag);
    rd_n = 0;
    @(negedge clk);
    req_vaddr = va; req_kind = kind; req_user = user; root_ppn = root; req_valid = 1;
    @(negedge clk);
    if (junk) begin
      req_vaddr = {$urandom, $urandom}; req_kind = 2'($urandom);
      req_user = 1'($urandom); root_ppn = {$urandom, $urandom};
    end else req_valid = 0;
    while (!done_valid && wait_c < 200) begin @(negedge clk); wait_c++; end
    req_valid = 0;
    if (!done_valid) begin
      check(0, {tag, " timeout"}, 0, 1);
      return;
    end
    check(done_fault == f && done_cause == c && done_paddr == pa && done_size == sz,
          {tag, junk ? " R11" : "", extra},
          {done_fault, done_cause, done_size, done_paddr}, {f, c, sz, pa});
    check(rd_n == ex_n && rd_addr[0] == ex_addr[0] &&
          (ex_n < 2 || rd_addr[1] == ex_addr[1]) && (ex_n < 3 || rd_addr[2] == ex_addr[2]),
          "R1 walk addresses", {rd_addr[rd_n > 0 ? rd_n-1 : 0][55:0], 8'(rd_n)},
          {ex_addr[ex_n-1], 8'(ex_n)});
    @(negedge clk);
    check(!done_valid && req_ready, "R11 single pulse", {done_valid, req_ready}, 2'b01);
  endtask

  task automatic dir(input int leaf_l, input logic [63:0] leaf, input logic [1:0] kind,
                     input bit user, input string tag);
    logic [38:0] va = {$urandom, $urandom};
    logic [43:0] root = {$urandom, $urandom};
    build(va, root, leaf_l, leaf);
    run(va, kind, user, root, 0, tag);
  endtask

  initial begin
    #(4 * 190000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check(req_ready && !done_valid && !mem_req_valid, "R11 reset state",
          {req_ready, done_valid, mem_req_valid}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    dir(0, mk(1,1,0,0,0,1,0,44'h123456789), 0, 0, " R2 4K read");
    dir(1, mk(1,1,1,0,1,1,1,44'hABCDE00), 1, 1, " R3 2M write");
    dir(2, mk(1,0,0,1,0,1,0,44'h7700000000), 2, 0, " R3 1G fetch");
    dir(1, mk(0,1,1,1,1,1,1,44'h0), 2, 0, " R4 fetch V=0");
    dir(0, mk(0,1,1,0,1,1,1,44'h1), 1, 0, " R4 write V=0");
    dir(0, mk(1,0,1,0,0,1,1,44'h5), 1, 0, " R5 write-only");
    dir(0, mk(1,1,0,0,0,1,1,44'h5) | 64'h1000_0000_0000_0000, 0, 0, " R5 reserved bit");
    dir(0, mk(1,0,0,1,0,1,1,44'h9), 0, 0, " R6 read on X page");
    dir(0, mk(1,1,1,0,0,1,1,44'h9), 2, 0, " R6 fetch on RW page");
    dir(0, mk(1,1,0,0,0,1,1,44'h9), 0, 1, " R7 user on S page");
    dir(0, mk(1,1,0,0,1,1,1,44'h9), 0, 0, " R7 supervisor on U page");
    dir(3, 64'd0, 0, 0, " R8 pointer at level 0");
    dir(1, mk(1,1,0,0,0,1,0,44'hABCDE01), 0, 0, " R9 misaligned 2M");
    dir(2, mk(1,1,0,0,0,1,0,44'h7700020000), 0, 0, " R9 misaligned 1G");
    dir(0, mk(1,1,1,0,0,0,1,44'h9), 0, 0, " R10 A=0");
    dir(0, mk(1,1,1,0,0,1,0,44'h9), 1, 0, " R10 write D=0");
    dir(0, mk(1,1,1,0,0,1,0,44'h9), 0, 0, " R10 read D=0");
    for (int i = 0; i < 400; i++) begin
      logic [38:0] va = {$urandom, $urandom};
      logic [43:0] root = {$urandom, $urandom};
      int lv = $urandom % 4;
      int pk = $urandom % 6;
      logic [43:0] pn = {$urandom, $urandom};
      bit r = (pk != 4 && pk != 5), w = (pk == 1 || pk == 3 || pk == 5), x = (pk == 2 || pk == 3 || pk == 4);
      if (lv == 1 && $urandom % 10 < 7) pn[8:0] = '0;
      if (lv == 2 && $urandom % 10 < 7) pn[17:0] = '0;
      build(va, root, lv, mk($urandom % 20 != 0, r, w, x, $urandom % 2,
                             $urandom % 10 != 0, $urandom % 5 != 0, pn));
      run(va, 2'($urandom % 3), $urandom % 2, root, $urandom % 2, " random");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule